// File: doc/BRIEF.md
# Manchester Framed Serial Transmitter

This block sends one self-delimiting serial frame on a single line each time it is started. A parallel load interface presents a 5-bit header, a 32-bit data word and a 32-bit check word together with a one-cycle start strobe. The block captures all three fields in that cycle and forms a 32-bit odd vertical parity word from them. It then drives the line through a long sync symbol, followed by the header, data, check and parity fields.

Every field bit is Manchester coded. Each bit has two equal halves whose length is a parameter counted in clock cycles. The sync symbol has its own half length and is three times as long as a field bit. A busy flag covers the whole frame, and a one-cycle done pulse follows it. The line rests low between frames. With a 100 MHz clock the default counts give 50 ns bit halves and 150 ns sync halves.

Top module: `mcx_frame_tx`

## Requirements
- R1: After reset and between frames, `line_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` high in a cycle where `busy_o` is low is accepted at that clock edge. From the next cycle `busy_o` is high, and the line is high for SYNC_CYC (15) cycles and then low for SYNC_CYC cycles.
- R3: After the sync symbol the fields follow in a fixed order: header, data word, check word, parity word. Each field is sent most significant bit first, 101 bits in all.
- R4: Each field bit takes 2*HALF_CYC cycles (5 + 5). A 1 is sent as high for HALF_CYC cycles and then low for HALF_CYC cycles. A 0 is sent as low and then high.
- R5: Parity bit i is 1 exactly when the header (zero-extended to 32 bits), the data word and the check word together hold an even number of ones at bit position i. This makes the total count of ones in that column odd.
- R6: The check word is sent exactly as loaded, including values other than zero.
- R7: `busy_o` stays high for exactly 2*SYNC_CYC + 101*2*HALF_CYC = 1040 consecutive cycles per frame.
- R8: `done_o` is high for exactly one cycle. That cycle is the first one in which `busy_o` is low after a frame.
- R9: A `start_i` high while `busy_o` is high is ignored. The running frame carries on unchanged, and input changes after acceptance do not affect it.
- R10: A start in the cycle where `done_o` is high is accepted, so frames can follow each other with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| hdr_i | input | HDR_W (5) | Header field |
| data_i | input | WORD_W (32) | Data field |
| chk_i | input | WORD_W (32) | Check field |
| line_o | output | 1 | Manchester coded serial line |
| busy_o | output | 1 | High for the whole frame |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bound checker watches the framing on every cycle. It confirms that the line is low whenever the block is idle, that an accepted start leads straight into a high sync level, and that busy only rises after a start. It also checks that each busy period lasts exactly the frame length and that the done pulse is a single cycle directly after busy falls.

The checker cannot see the bit contents: field order, bit polarity, the parity values, passing through a non-zero check word, and that a mid-frame start leaves the frame untouched. Those are shown only by the bench. It compares the line against a queued reference waveform on every cycle and decodes each captured frame back into its fields.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SYNC_HI,
      PH_SYNC_LO,
      PH_BIT_A,
      PH_BIT_B
   } mcx_phase_e;

   // Counter width able to hold (max(a,b) - 1), at least one bit.
   function automatic int mcx_cnt_w(input int a, input int b);
      int m;
      m = (a > b) ? a : b;
      return (m < 3) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/mcx_parity.sv
module mcx_parity #(
   parameter int HDR_W  = 5,
   parameter int WORD_W = 32
) (
   input  logic [HDR_W-1:0]  hdr_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [WORD_W-1:0] chk_i,
   output logic [WORD_W-1:0] par_o
);

   logic [WORD_W-1:0] hdr_ext;

   generate
      if (HDR_W > WORD_W) begin : g_bad_width
         $error("mcx_parity: HDR_W must not exceed WORD_W");
      end
      if (HDR_W == WORD_W) begin : g_hdr_full
         assign hdr_ext = hdr_i;
      end else begin : g_hdr_pad
         assign hdr_ext = {{(WORD_W-HDR_W){1'b0}}, hdr_i};
      end
   endgenerate

   // One column per output bit: odd total count of ones.
   generate
      for (genvar i = 0; i < WORD_W; i++) begin : g_col
         assign par_o[i] = ~(hdr_ext[i] ^ data_i[i] ^ chk_i[i]);
      end
   endgenerate

endmodule

// File: rtl/mcx_halftimer.sv
module mcx_halftimer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/mcx_frame_shift.sv
module mcx_frame_shift #(
   parameter int FRAME_W = 101
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               shift_i,
   output logic               msb_o,
   output logic               last_o
);

   localparam int IDX_W = (FRAME_W < 3) ? 1 : $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   idx_q;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("mcx_frame_shift: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         idx_q   <= '0;
      end else if (load_i) begin
         frame_q <= frame_i;
         idx_q   <= IDX_TOP;
      end else if (shift_i) begin
         frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
         idx_q   <= idx_q - 1'b1;
      end
   end

   assign msb_o  = frame_q[FRAME_W-1];
   assign last_o = (idx_q == '0);

endmodule

// File: rtl/mcx_frame_tx.sv
module mcx_frame_tx
   import mcx_pkg::*;
#(
   parameter int HDR_W    = 5,
   parameter int WORD_W   = 32,
   parameter int HALF_CYC = 5,
   parameter int SYNC_CYC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [HDR_W-1:0]  hdr_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [WORD_W-1:0] chk_i,
   output logic              line_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int FRAME_W = HDR_W + 3 * WORD_W;
   localparam int CNT_W   = mcx_cnt_w(HALF_CYC, SYNC_CYC);
   localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] SYNC_LD = CNT_W'(SYNC_CYC - 1);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("mcx_frame_tx: HALF_CYC must be at least 1");
      end
      if (SYNC_CYC < 1) begin : g_bad_sync
         $error("mcx_frame_tx: SYNC_CYC must be at least 1");
      end
      if (HDR_W < 1 || WORD_W < 1) begin : g_bad_fields
         $error("mcx_frame_tx: field widths must be positive");
      end
   endgenerate

   mcx_phase_e phase_q, phase_d;
   logic       done_q;
   logic       accept;
   logic       expired;
   logic       tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic       bit_msb;
   logic       bit_last;
   logic       shift_en;
   logic [WORD_W-1:0]  par_word;
   logic [FRAME_W-1:0] frame_word;

   assign accept = (phase_q == PH_IDLE) && start_i;

   mcx_parity #(.HDR_W(HDR_W), .WORD_W(WORD_W)) u_par (
      .hdr_i  (hdr_i),
      .data_i (data_i),
      .chk_i  (chk_i),
      .par_o  (par_word)
   );

   assign frame_word = {hdr_i, data_i, chk_i, par_word};

   assign tmr_load = accept || ((phase_q != PH_IDLE) && expired);
   assign tmr_val  = (accept || (phase_q == PH_SYNC_HI)) ? SYNC_LD : HALF_LD;

   mcx_halftimer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (expired)
   );

   assign shift_en = (phase_q == PH_BIT_B) && expired && !bit_last;

   mcx_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .frame_i (frame_word),
      .shift_i (shift_en),
      .msb_o   (bit_msb),
      .last_o  (bit_last)
   );

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:    if (start_i) phase_d = PH_SYNC_HI;
         PH_SYNC_HI: if (expired) phase_d = PH_SYNC_LO;
         PH_SYNC_LO: if (expired) phase_d = PH_BIT_A;
         PH_BIT_A:   if (expired) phase_d = PH_BIT_B;
         PH_BIT_B:   if (expired) phase_d = bit_last ? PH_IDLE : PH_BIT_A;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_BIT_B) && expired && bit_last;
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_SYNC_HI: line_o = 1'b1;
         PH_BIT_A:   line_o = bit_msb;
         PH_BIT_B:   line_o = ~bit_msb;
         default:    line_o = 1'b0;
      endcase
   end

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/mcx_frame_tx_chk.sv
module mcx_frame_tx_chk #(
   parameter int FRAME_CYC = 1040
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic line_o,
   input logic busy_o,
   input logic done_o
);

   localparam int RUN_W = $clog2(FRAME_CYC + 2);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_q <= '0;
      else if (busy_o) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_o);

   p_sync_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && line_o));

   p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_q == RUN_W'(FRAME_CYC)));

   p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind mcx_frame_tx mcx_frame_tx_chk #(
   .FRAME_CYC(2 * SYNC_CYC + (HDR_W + 3 * WORD_W) * 2 * HALF_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .line_o  (line_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/sim_mcx_frame_tx.sv
`timescale 1ns/1ps
module sim_mcx_frame_tx;

   localparam int HDR_W     = 5;
   localparam int WORD_W    = 32;
   localparam int HALF_CYC  = 5;
   localparam int SYNC_CYC  = 15;
   localparam int FRAME_W   = HDR_W + 3 * WORD_W;
   localparam int FRAME_CYC = 2 * SYNC_CYC + FRAME_W * 2 * HALF_CYC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [HDR_W-1:0]  hdr_i = '0;
   logic [WORD_W-1:0] data_i = '0;
   logic [WORD_W-1:0] chk_i = '0;
   logic              line_o, busy_o, done_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   mcx_frame_tx #(
      .HDR_W(HDR_W), .WORD_W(WORD_W), .HALF_CYC(HALF_CYC), .SYNC_CYC(SYNC_CYC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_i(hdr_i),
      .data_i(data_i), .chk_i(chk_i),
      .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Parity from the requirement: count ones per column.
   function automatic logic [WORD_W-1:0] ref_par(input logic [HDR_W-1:0] h,
      input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] c);
      logic [WORD_W-1:0] p;
      for (int i = 0; i < WORD_W; i++) begin
         int ones;
         ones = int'(d[i]) + int'(c[i]);
         if (i < HDR_W) ones += int'(h[i]);
         p[i] = (ones % 2 == 0);
      end
      return p;
   endfunction

   // Reference model: queue of future line levels
   bit exp_q[$];
   bit exp_line = 1'b0, exp_busy = 1'b0, exp_done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
         exp_done = 1'b0;
      end else begin
         bit was_idle;
         was_idle = (exp_q.size() == 0);
         exp_done = 1'b0;
         if (!was_idle) begin
            void'(exp_q.pop_front());
            if (exp_q.size() == 0) exp_done = 1'b1;
         end
         if (was_idle && start_i) begin
            logic [FRAME_W-1:0] f;
            f = {hdr_i, data_i, chk_i, ref_par(hdr_i, data_i, chk_i)};
            for (int k = 0; k < SYNC_CYC; k++) exp_q.push_back(1'b1);
            for (int k = 0; k < SYNC_CYC; k++) exp_q.push_back(1'b0);
            for (int b = FRAME_W - 1; b >= 0; b--) begin
               for (int k = 0; k < HALF_CYC; k++) exp_q.push_back(f[b]);
               for (int k = 0; k < HALF_CYC; k++) exp_q.push_back(~f[b]);
            end
         end
      end
      exp_busy = (exp_q.size() != 0);
      exp_line = exp_busy ? exp_q[0] : 1'b0;
   end

   // Per-cycle comparison (R4 line, R7 busy, R8 done)
   always @(negedge clk) begin
      if (rst_n) begin
         check({line_o, busy_o, done_o} === {exp_line, exp_busy, exp_done},
               "R4/R7/R8 per-cycle line,busy,done",
               {29'd0, line_o, busy_o, done_o},
               {29'd0, exp_line, exp_busy, exp_done});
      end
   end

   // Capture of the line during busy
   bit cap[$];
   always @(negedge clk) begin
      if (rst_n && busy_o) cap.push_back(line_o);
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R7 actual=%0d expected<%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic launch(input logic [HDR_W-1:0] h, input logic [WORD_W-1:0] d,
                         input logic [WORD_W-1:0] c, input bit now);
      if (!now) @(negedge clk);
      cap.delete();
      hdr_i = h; data_i = d; chk_i = c; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done_o);
   endtask

   task automatic verify(input logic [HDR_W-1:0] h, input logic [WORD_W-1:0] d,
                         input logic [WORD_W-1:0] c);
      logic [FRAME_W-1:0] got;
      logic [WORD_W-1:0]  par_e;
      bit sync_ok, man_ok;
      par_e = ref_par(h, d, c);
      check(cap.size() == FRAME_CYC, "R7 busy length",
            32'(cap.size()), 32'(FRAME_CYC));
      if (cap.size() != FRAME_CYC) return;
      sync_ok = 1'b1;
      for (int k = 0; k < SYNC_CYC; k++) begin
         if (cap[k] !== 1'b1) sync_ok = 1'b0;
         if (cap[SYNC_CYC + k] !== 1'b0) sync_ok = 1'b0;
      end
      check(sync_ok, "R2 sync symbol", 32'(sync_ok), 32'd1);
      man_ok = 1'b1;
      for (int b = 0; b < FRAME_W; b++) begin
         int base;
         base = 2 * SYNC_CYC + 2 * HALF_CYC * b;
         got[FRAME_W - 1 - b] = cap[base];
         for (int k = 0; k < HALF_CYC; k++) begin
            if (cap[base + k] !== cap[base]) man_ok = 1'b0;
            if (cap[base + HALF_CYC + k] !== ~cap[base]) man_ok = 1'b0;
         end
      end
      check(man_ok, "R4 Manchester halves", 32'(man_ok), 32'd1);
      check(got[FRAME_W-1 -: HDR_W] === h, "R3 header field",
            32'(got[FRAME_W-1 -: HDR_W]), 32'(h));
      check(got[3*WORD_W-1 -: WORD_W] === d, "R3 data field",
            got[3*WORD_W-1 -: WORD_W], d);
      check(got[2*WORD_W-1 -: WORD_W] === c, "R6 check field",
            got[2*WORD_W-1 -: WORD_W], c);
      check(got[WORD_W-1:0] === par_e, "R5 parity field",
            got[WORD_W-1:0], par_e);
   endtask

   task automatic idle_check(input string tag);
      check({line_o, busy_o} === 2'b00, tag, {30'd0, line_o, busy_o}, 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({line_o, busy_o, done_o} === 3'b000, "R1 reset state",
            {29'd0, line_o, busy_o, done_o}, 32'd0);

      // Typical frame, check word zero
      launch(5'h15, 32'hA5C3_0F96, 32'h0, 1'b0);
      wait_done();
      check(!busy_o, "R8 done when busy low", 32'(busy_o), 32'd0);
      verify(5'h15, 32'hA5C3_0F96, 32'h0);
      @(negedge clk);
      check(!done_o, "R8 done lasts one cycle", 32'(done_o), 32'd0);
      idle_check("R1 idle between frames");

      // All ones with nonzero check word (R6)
      launch(5'h1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      wait_done();
      verify(5'h1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      // All zeros: parity all ones (R5)
      launch(5'h00, 32'h0, 32'h0, 1'b0);
      wait_done();
      verify(5'h00, 32'h0, 32'h0);

      // R9: start pulses and input changes mid-frame are ignored
      launch(5'h0A, 32'h1234_5678, 32'h8000_0001, 1'b0);
      repeat (300) @(negedge clk);
      hdr_i = 5'h11; data_i = 32'hDEAD_BEEF; chk_i = 32'h5555_AAAA; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (400) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R9 frame still running", 32'(busy_o), 32'd1);
      wait_done();
      verify(5'h0A, 32'h1234_5678, 32'h8000_0001);

      // R10: back-to-back start during the done cycle
      launch(5'h13, 32'h0F0F_00FF, 32'h0000_0000, 1'b1);
      check(busy_o && line_o, "R10 back-to-back start accepted",
            {30'd0, busy_o, line_o}, 32'd3);
      wait_done();
      verify(5'h13, 32'h0F0F_00FF, 32'h0);
      repeat (3) @(negedge clk);
      idle_check("R1 idle after last frame");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule